// File: doc/BRIEF.md
# External Memory Bus Interface Controller

This block stands between a small processor core's data-move requests and two groups of shared general-purpose port pins. It examines each request and sends it either to the on-chip RAM port or to an external bus. The choice depends on a two-bit memory mode and on the request address. Requests that carry only an 8-bit address take their upper byte from a page register, in every mode except the flat split mode.

An external access borrows the pins of one group. The group is chosen by a configuration bit. During the access the block drives the address, the data, an active-low read strobe, an active-low write strobe and, when multiplexed address/data mode is on, an address latch enable. At all other times each pin carries the value the port latches present. A sequencer steps through the states ST_IDLE, ST_ALE, ST_SETUP, ST_STROBE, ST_HOLD and ST_DONE. Its transitions are:

- ST_IDLE→ST_ALE on an accepted request in multiplexed mode.
- ST_IDLE→ST_SETUP on an accepted request when the setup count is non-zero.
- ST_IDLE→ST_STROBE on an accepted request when the setup count is zero.
- ST_ALE→ST_SETUP always.
- ST_SETUP→ST_STROBE when its counter expires.
- ST_STROBE→ST_HOLD when its counter expires and the hold count is non-zero.
- ST_STROBE→ST_DONE when its counter expires and the hold count is zero.
- ST_HOLD→ST_DONE when its counter expires.
- ST_DONE→ST_IDLE always.

Top module: `emif_ctrl`

## Requirements
- R1: Three registers are reachable through the write port and read back combinationally on `cfg_rdata`. Index 0 is the page register. Index 1 is control: bits [1:0] mode, bit 2 multiplex enable, bit 3 group select. Index 2 is timing: bits [1:0] setup, bits [5:2] pulse, bits [7:6] hold. All three reset to 0x00.
- R2: A short request (`req_short`=1) uses the address {page, `req_addr`[7:0]}, except in mode 1, where `req_addr` is used unchanged.
- R3: Mode 0 sends every request on-chip and mode 3 sends every request off-chip. In modes 1 and 2, an address below 0x1000 goes on-chip and an address at 0x1000 or above goes off-chip. An on-chip request raises `onc_sel` in the same cycle, with the formed address on `onc_addr`.
- R4: While no off-chip access is in progress, both pin groups equal their latch inputs. This holds during on-chip requests too.
- R5: Group select 0 places an access on `pins_a` and group select 1 places it on `pins_b`. The other group keeps its latch value.
- R6: The pin vector is arranged as follows: [7:0] data, [15:8] low address, [23:16] high address, [24] read strobe (active low), [25] write strobe (active low), [26] latch enable. Exactly one strobe goes low, for pulse+1 cycles, and only the strobe that matches the direction.
- R7: In multiplexed mode, the first owned cycle has the latch enable high and the low address on the data pins. At least one setup cycle always separates it from the strobe.
- R8: An access owns the pins for M+S+P+H consecutive cycles starting the cycle after acceptance. M is 1 in multiplexed mode and 0 otherwise. S is the setup count, raised to a minimum of 1 in multiplexed mode. P is pulse+1. H is the hold count.
- R9: `req_done` is high for one cycle, in the cycle after ownership ends. For a read, `req_rdata` then holds the selected group's data input as sampled in the last strobe cycle, and keeps it until the next read.
- R10: During a read, data-pin drivers are disabled (`pad_dis` of the owning group) in every owned cycle except the latch-enable cycle. During a write, the data pins carry the write data outside the latch-enable cycle.
- R11: A request that arrives while an access is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| req_valid | input | 1 | Core data-move request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | Request carries only an 8-bit address |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_done | output | 1 | One-cycle completion of an off-chip access |
| req_rdata | output | 8 | Captured read data |
| onc_sel | output | 1 | Request routed to on-chip RAM |
| onc_addr | output | 16 | Formed address |
| latch_a | input | 27 | Port latch values, group A |
| latch_b | input | 27 | Port latch values, group B |
| din_a | input | 8 | Data pin inputs, group A |
| din_b | input | 8 | Data pin inputs, group B |
| pins_a | output | 27 | Pin outputs, group A |
| pins_b | output | 27 | Pin outputs, group B |
| pad_dis_a | output | 1 | Data driver disable, group A |
| pad_dis_b | output | 1 | Data driver disable, group B |

## Verification
Directed cases cover the addresses on each side of the on-chip boundary, reached both through the page register and through the full bus. Together they separate a wrong comparison, a wrong address source and a wrong mode decode. The timing extremes are also directed: all counts zero, and setup 3 with pulse 15 and hold 3. These expose phase-length and skip errors, and the multiplexed case with a zero setup count shows whether the latch enable is kept apart from the strobe. Random configurations, directions and addresses then compare every pin of both groups on every cycle with a phase model. The data inputs change on every cycle, so a read capture taken in the wrong cycle returns a different value. A second request raised during a busy access shows whether it is ignored.

// File: rtl/emif_pkg.sv
package emif_pkg;
    typedef enum logic [1:0] {
        MODE_ONCHIP      = 2'd0,
        MODE_SPLIT_FLAT  = 2'd1,
        MODE_SPLIT_PAGED = 2'd2,
        MODE_OFFCHIP     = 2'd3
    } mem_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ALE, ST_SETUP, ST_STROBE, ST_HOLD, ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [1:0] hold;
        logic [3:0] pulse;
        logic [1:0] setup;
    } timing_t;

    typedef struct packed {
        logic      grp;
        logic      mux;
        mem_mode_e mode;
    } ctrl_t;
endpackage

// File: rtl/emif_regs.sv
module emif_regs
    import emif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] page,
    output ctrl_t         ctrl,
    output timing_t       tim
);
    localparam int CW = $bits(ctrl_t);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
            ctrl <= '0;
            tim  <= '0;
        end else if (we) begin
            unique case (idx)
                2'd0:    page <= wdata;
                2'd1:    ctrl <= ctrl_t'(wdata[CW-1:0]);
                2'd2:    tim  <= timing_t'(wdata[$bits(timing_t)-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            2'd0:    rdata = page;
            2'd1:    rdata = DW'(ctrl);
            2'd2:    rdata = DW'(tim);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/emif_route.sv
module emif_route
    import emif_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int BOUND = 'h1000
) (
    input  mem_mode_e     mode,
    input  logic [DW-1:0] page,
    input  logic          short_req,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] eff_addr,
    output logic          off
);
    localparam int HW = AW - DW;

    always_comb begin
        if (short_req && mode != MODE_SPLIT_FLAT)
            eff_addr = {page[HW-1:0], addr[DW-1:0]};
        else
            eff_addr = addr;
        unique case (mode)
            MODE_ONCHIP:  off = 1'b0;
            MODE_OFFCHIP: off = 1'b1;
            default:      off = (32'(eff_addr) >= BOUND);
        endcase
    end
endmodule

// File: rtl/emif_seq.sv
module emif_seq
    import emif_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    localparam int GW = AW + DW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mux,
    input  logic          grp,
    input  timing_t       tim,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] din,
    output logic [GW-1:0] drv,
    output logic          own,
    output logic          dis,
    output logic          grp_q,
    output logic          done,
    output logic [DW-1:0] rdata
);
    seq_state_e    st, st_nx;
    logic [3:0]    cnt, cnt_nx;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          wr_q;
    timing_t       tim_q;
    logic          ale, rd_n, wr_n;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            ST_IDLE: if (start) begin
                if (mux) begin
                    st_nx = ST_ALE;
                end else if (tim.setup != 2'd0) begin
                    st_nx  = ST_SETUP;
                    cnt_nx = {2'b00, tim.setup} - 4'd1;
                end else begin
                    st_nx  = ST_STROBE;
                    cnt_nx = tim.pulse;
                end
            end
            ST_ALE: begin
                st_nx  = ST_SETUP;
                cnt_nx = (tim_q.setup == 2'd0) ? 4'd0 : {2'b00, tim_q.setup} - 4'd1;
            end
            ST_SETUP: begin
                if (cnt == 4'd0) begin
                    st_nx  = ST_STROBE;
                    cnt_nx = tim_q.pulse;
                end else cnt_nx = cnt - 4'd1;
            end
            ST_STROBE: begin
                if (cnt != 4'd0) cnt_nx = cnt - 4'd1;
                else if (tim_q.hold != 2'd0) begin
                    st_nx  = ST_HOLD;
                    cnt_nx = {2'b00, tim_q.hold} - 4'd1;
                end else st_nx = ST_DONE;
            end
            ST_HOLD: begin
                if (cnt == 4'd0) st_nx = ST_DONE;
                else cnt_nx = cnt - 4'd1;
            end
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            grp_q   <= 1'b0;
            tim_q   <= '0;
            rdata   <= '0;
        end else begin
            if (st == ST_IDLE && start) begin
                addr_q  <= addr;
                wdata_q <= wdata;
                wr_q    <= wr;
                grp_q   <= grp;
                tim_q   <= tim;
            end
            if (st == ST_STROBE && cnt == 4'd0 && !wr_q) rdata <= din;
        end
    end

    always_comb begin
        own  = 1'b0;
        ale  = 1'b0;
        rd_n = 1'b1;
        wr_n = 1'b1;
        done = 1'b0;
        unique case (st)
            ST_ALE:    begin own = 1'b1; ale = 1'b1; end
            ST_SETUP:  own = 1'b1;
            ST_STROBE: begin own = 1'b1; rd_n = wr_q; wr_n = !wr_q; end
            ST_HOLD:   own = 1'b1;
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
        dis = own && !wr_q && !ale;
        drv = {ale, wr_n, rd_n, addr_q, ale ? addr_q[DW-1:0] : wdata_q};
    end

    AST_ALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STROBE) |-> !$past(st == ST_ALE));                  // R7
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                             // R9
    AST_DONE_AFTER_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(own));                                        // R8
    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(st == ST_STROBE) |-> $stable(rdata));                 // R9
    AST_BUSY_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (own && start) |=> (st != ST_ALE || $past(st) == ST_IDLE));  // R11
endmodule

// File: rtl/emif_ctrl.sv
module emif_ctrl
    import emif_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 8,
    parameter int BOUND = 'h1000,
    localparam int GW   = AW + DW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_short,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_done,
    output logic [DW-1:0] req_rdata,
    output logic          onc_sel,
    output logic [AW-1:0] onc_addr,
    input  logic [GW-1:0] latch_a,
    input  logic [GW-1:0] latch_b,
    input  logic [DW-1:0] din_a,
    input  logic [DW-1:0] din_b,
    output logic [GW-1:0] pins_a,
    output logic [GW-1:0] pins_b,
    output logic          pad_dis_a,
    output logic          pad_dis_b
);
    localparam int NGRP = 2;

    logic [DW-1:0]           page;
    ctrl_t                   ctrl;
    timing_t                 tim;
    logic [AW-1:0]           eff_addr;
    logic                    off, own, dis, grp_q;
    logic [GW-1:0]           drv;
    logic [NGRP-1:0][GW-1:0] latch_v, pins_v;
    logic [NGRP-1:0]         dis_v, own_v;

    emif_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_addr), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .page(page), .ctrl(ctrl), .tim(tim)
    );

    emif_route #(.AW(AW), .DW(DW), .BOUND(BOUND)) u_route (
        .mode(ctrl.mode), .page(page), .short_req(req_short), .addr(req_addr),
        .eff_addr(eff_addr), .off(off)
    );

    emif_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(req_valid && off), .mux(ctrl.mux),
        .grp(ctrl.grp), .tim(tim), .addr(eff_addr), .wr(req_write),
        .wdata(req_wdata), .din(grp_q ? din_b : din_a), .drv(drv), .own(own),
        .dis(dis), .grp_q(grp_q), .done(req_done), .rdata(req_rdata)
    );

    assign onc_sel  = req_valid && !off;
    assign onc_addr = eff_addr;
    assign latch_v  = {latch_b, latch_a};

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign own_v[g]  = own && (grp_q == 1'(g));
        assign pins_v[g] = own_v[g] ? drv : latch_v[g];
        assign dis_v[g]  = own_v[g] && dis;
    end

    assign pins_a    = pins_v[0];
    assign pins_b    = pins_v[1];
    assign pad_dis_a = dis_v[0];
    assign pad_dis_b = dis_v[1];

    AST_ONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(own_v));                                            // R5
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_v[grp_q][24] || pins_v[grp_q][25] || !own));           // R6
    AST_DIS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_dis_a || pad_dis_b) |-> own);                           // R10
endmodule

// File: tb/emif_ctrl_bench.sv
module emif_ctrl_bench;
    localparam int GW = 27;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_addr;
    logic [7:0]    cfg_wdata, cfg_rdata;
    logic          req_valid, req_write, req_short;
    logic [15:0]   req_addr, onc_addr;
    logic [7:0]    req_wdata, req_rdata;
    logic          req_done, onc_sel;
    logic [GW-1:0] latch_a, latch_b, pins_a, pins_b;
    logic [7:0]    din_a, din_b;
    logic          pad_dis_a, pad_dis_b;

    int total = 0;
    int fails = 0;

    logic [7:0] page_m;
    logic [1:0] mode_m, su_m, ho_m;
    logic [3:0] pw_m;
    logic       mux_m, grp_m;

    always #2 clk = ~clk;

    emif_ctrl u_emif_ctrl (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] pg, input logic [1:0] md, input logic mx,
                           input logic gp, input logic [1:0] su, input logic [3:0] pw,
                           input logic [1:0] ho);
        page_m = pg; mode_m = md; mux_m = mx; grp_m = gp; su_m = su; pw_m = pw; ho_m = ho;
        cfg_wr(2'd0, pg);
        cfg_wr(2'd1, {4'b0, gp, mx, md});
        cfg_wr(2'd2, {ho, pw, su});
    endtask

    function automatic logic [15:0] form_addr(input logic sh, input logic [15:0] a);
        return (sh && mode_m != 2'd1) ? {page_m, a[7:0]} : a;
    endfunction

    function automatic bit goes_off(input logic [15:0] ea);
        if (mode_m == 2'd0) return 1'b0;
        if (mode_m == 2'd3) return 1'b1;
        return ea >= 16'h1000;
    endfunction

    function automatic logic [7:0] din_val(input logic [7:0] base, input int k);
        return base ^ 8'(k * 29);
    endfunction

    task automatic run_xfer(input bit wr, input bit sh, input logic [15:0] a,
                            input logic [7:0] wd, input bit poke);
        logic [15:0]   ea;
        bit            off;
        int            m, s, p, h, n, lst, ph;
        logic [7:0]    base;
        logic [GW-1:0] ev, mask, sel_pins, oth_pins, sel_lat, oth_lat;
        logic          sel_dis, oth_dis, exp_dis;
        ea = form_addr(sh, a);
        off = goes_off(ea);
        base = 8'($urandom);
        latch_a = GW'({$urandom, $urandom});
        latch_b = GW'({$urandom, $urandom});
        din_a = base; din_b = ~base;
        req_valid = 1'b1; req_write = wr; req_short = sh; req_addr = a; req_wdata = wd;
        #1;
        chk(onc_sel == !off, "R3 onc_sel", 64'(onc_sel), 64'(!off));
        if (!off) begin
            chk(onc_addr == ea, "R2 onc_addr", 64'(onc_addr), 64'(ea));
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                req_valid = 1'b0;
                chk(pins_a == latch_a && pins_b == latch_b && !req_done, "R4 on-chip idle pins",
                    {pins_a, 5'b0, pins_b[26:0]}, {latch_a, 5'b0, latch_b});
            end
            return;
        end
        m = mux_m ? 1 : 0;
        s = (mux_m && su_m == 2'd0) ? 1 : int'(su_m);
        p = int'(pw_m) + 1;
        h = int'(ho_m);
        n = m + s + p + h;
        lst = m + s + p;
        sel_lat = grp_m ? latch_b : latch_a;
        oth_lat = grp_m ? latch_a : latch_b;
        for (int k = 1; k <= n + 2; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (poke && k == 2) begin req_valid = 1'b1; req_addr = ~a; req_short = 1'b0; end
            if (poke && k == 3) req_valid = 1'b0;
            if (k <= m) ph = 0;
            else if (k <= m + s) ph = 1;
            else if (k <= lst) ph = 2;
            else if (k <= n) ph = 3;
            else ph = 4;
            mask = '1;
            if (ph == 4) begin
                ev = sel_lat;
            end else begin
                ev = {ph == 0, !(ph == 2 && wr), !(ph == 2 && !wr), ea,
                      (ph == 0) ? ea[7:0] : wd};
                if (!wr && ph != 0) mask[7:0] = 8'h00;
            end
            exp_dis = (ph != 0 && ph != 4 && !wr);
            sel_pins = grp_m ? pins_b : pins_a;
            oth_pins = grp_m ? pins_a : pins_b;
            sel_dis = grp_m ? pad_dis_b : pad_dis_a;
            oth_dis = grp_m ? pad_dis_a : pad_dis_b;
            chk((sel_pins & mask) == (ev & mask), "R4 R6 R7 R8 R11 owned-group pins",
                64'(sel_pins & mask), 64'(ev & mask));
            chk(oth_pins == oth_lat && !oth_dis, "R5 other group parked", 64'(oth_pins), 64'(oth_lat));
            chk(sel_dis == exp_dis, "R10 pad disable", 64'(sel_dis), 64'(exp_dis));
            chk(req_done == (k == n + 1), "R9 R11 done pulse", 64'(req_done), 64'(k == n + 1));
            if (k == n + 1 && !wr)
                chk(req_rdata == din_val(base, lst), "R9 read capture",
                    64'(req_rdata), 64'(din_val(base, lst)));
            if (grp_m) begin din_b = din_val(base, k); din_a = ~din_val(base, k); end
            else begin din_a = din_val(base, k); din_b = ~din_val(base, k); end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        req_valid = 1'b0; req_write = 1'b0; req_short = 1'b0; req_addr = '0; req_wdata = '0;
        latch_a = '1; latch_b = 27'h2AAAAAA; din_a = '0; din_b = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            cfg_addr = 2'(i); #1;
            chk(cfg_rdata == 8'h00, "R1 reset value", 64'(cfg_rdata), 64'h0);
        end
        chk(pins_a == latch_a && pins_b == latch_b && !req_done && !pad_dis_a && !pad_dis_b,
            "R4 reset pins parked", 64'(pins_a), 64'(latch_a));
        cfg_wr(2'd0, 8'h5A);
        cfg_addr = 2'd0; #1;
        chk(cfg_rdata == 8'h5A, "R1 page readback", 64'(cfg_rdata), 64'h5A);
        cfg_wr(2'd2, 8'hC9);
        cfg_addr = 2'd2; #1;
        chk(cfg_rdata == 8'hC9, "R1 timing readback", 64'(cfg_rdata), 64'hC9);

        set_cfg(8'h5A, 2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 2'd0);
        @(negedge clk); run_xfer(1'b0, 1'b1, 16'h0034, 8'h00, 1'b0);
        set_cfg(8'h00, 2'd1, 1'b1, 1'b1, 2'd0, 4'd3, 2'd2);
        @(negedge clk); run_xfer(1'b1, 1'b0, 16'h1000, 8'hC3, 1'b1);
        @(negedge clk); run_xfer(1'b0, 1'b1, 16'h0FFF, 8'h00, 1'b0);
        set_cfg(8'h77, 2'd0, 1'b0, 1'b0, 2'd1, 4'd1, 2'd1);
        @(negedge clk); run_xfer(1'b1, 1'b0, 16'hFFFF, 8'h11, 1'b0);
        set_cfg(8'h00, 2'd3, 1'b0, 1'b1, 2'd2, 4'd2, 2'd0);
        @(negedge clk); run_xfer(1'b0, 1'b0, 16'h0000, 8'h00, 1'b0);
        set_cfg(8'h0F, 2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 2'd0);
        @(negedge clk); run_xfer(1'b1, 1'b1, 16'hABFF, 8'h22, 1'b0);
        set_cfg(8'h10, 2'd2, 1'b0, 1'b0, 2'd0, 4'd0, 2'd0);
        @(negedge clk); run_xfer(1'b1, 1'b1, 16'hAB00, 8'h33, 1'b0);
        set_cfg(8'h80, 2'd3, 1'b1, 1'b0, 2'd3, 4'd15, 2'd3);
        @(negedge clk); run_xfer(1'b0, 1'b1, 16'h0042, 8'h00, 1'b1);

        for (int t = 0; t < 60; t++) begin
            set_cfg(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                    2'($urandom), 4'($urandom), 2'($urandom));
            @(negedge clk);
            run_xfer(1'($urandom), 1'($urandom), 16'($urandom), 8'($urandom), t % 7 == 0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule